// File: doc/BRIEF.md
# Dual-Channel Serial Port Register Front End

This block is the processor-facing register set for two character channels: a console channel (A) and an auxiliary channel (B). A simple one-cycle bus reads and writes byte registers. Each channel takes received bytes from a byte-wide valid/data link. Each channel also sends bytes out on a byte-wide valid/data link. Baud timing and bit shifting happen elsewhere.

Per channel there are three registers: a status register, a command register and a holding register. The two channels share one interrupt register, which holds the mask when written and returns the pending status when read. All interrupt causes drive a single interrupt line.

Receive-ready interrupts come from arriving bytes. Transmit-ready interrupts are not produced by real transmitter state. They come from an external periodic tick, and fire on every second tick. The transmitter always reports itself ready.

The mode, auxiliary-control and counter registers are accepted and have no effect. Read data appears on the cycle after the read strobe.

Top module: `dcuart_frontend`

## Requirements
- R1: A channel status read returns bit 0 = a received byte is waiting, bit 2 = 1 always (transmitter ready), bit 4 = sticky overrun, and all other bits 0. Channel A status sits at offset 0x0C and channel B status at 0x4C.
- R2: Reading a holding register (A at 0x1C, B at 0x5C) returns the last received byte. It also clears that channel's byte-waiting flag and that channel's receive-ready interrupt status bit.
- R3: A byte that arrives while the previous one is still unread replaces it and sets the overrun bit. The overrun bit stays set until reset.
- R4: Offset 0x2C is the shared interrupt register: a write loads the mask and a read returns the status. Its bits are A transmit-ready = bit 0, A receive-ready = bit 1, B transmit-ready = bit 4 and B receive-ready = bit 5.
- R5: A byte arriving on a channel whose receive-ready mask bit is set sets that channel's receive-ready status bit and asserts the interrupt line on the next cycle. With the mask bit clear, neither the status bit nor the line changes.
- R6: Every second tick, if mask bit 0 or mask bit 4 is set, both transmit-ready status bits are set and the interrupt line is asserted. With both of those mask bits clear, ticks change nothing.
- R7: Writing a holding register produces a one-cycle transmit valid pulse carrying the written byte on that channel. It also clears that channel's transmit-ready status bit.
- R8: Reading channel A status deasserts the interrupt line. Reading channel B status leaves the line unchanged.
- R9: Writing a command register (A at 0x14, B at 0x54) with bit 3 set gives a one-cycle flush pulse on that channel. A write with bit 3 clear gives no pulse.
- R10: Reads of any other offset (the ignored mode, auxiliary-control and counter registers included) return 0, and writes to them change no state.
- R11: After reset the interrupt line is low, the interrupt status and mask are 0, no pulses are driven, and each status register reads 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid_i | input | 1 | Register access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| rx_valid_i | input | 2 | Per-channel received byte strobe (bit 0 = A) |
| rx_data_i | input | 16 | Per-channel received byte (A in [7:0]) |
| tx_valid_o | output | 2 | Per-channel transmit byte pulse |
| tx_data_o | output | 16 | Per-channel transmit byte |
| flush_o | output | 2 | Per-channel transmit flush pulse |
| tick_i | input | 1 | Periodic tick for transmit-ready interrupts |
| irq_o | output | 1 | Shared interrupt line |

## Verification
The hardest state to reach is the phase of the tick divider. It can only be seen through the interrupt status, and only while a transmit-ready mask bit is set. The stimulus therefore sets the mask first, then issues single ticks with a status read after each. This shows the silent first tick and the firing second tick. Ticks are then issued with the mask cleared, which shows that they change nothing. Overrun is reached by delivering a second byte to channel B before any holding read. A status read then shows the overrun flag, and a holding read afterwards shows the newer byte.

// File: rtl/dcuart_pkg.sv
package dcuart_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_CH    = 2;
    localparam int CH_STRIDE = 'h40;
    localparam int OFF_STAT  = 'h0C;
    localparam int OFF_CMD   = 'h14;
    localparam int OFF_HOLD  = 'h1C;
    localparam int OFF_INTR  = 'h2C;
    localparam int FLUSH_BIT = 3;
    localparam int TXR_BIT   = 0;   // offset of tx-ready bit within a channel nibble
    localparam int RXR_BIT   = 1;   // offset of rx-ready bit within a channel nibble

    typedef struct packed {
        logic              full;
        logic              ovr;
        logic [BYTE_W-1:0] hold;
        logic              tx_vld;
        logic [BYTE_W-1:0] tx_byte;
        logic              flush;
    } chan_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] isr;
        logic [BYTE_W-1:0] imr;
        logic              seq;
        logic              irq;
    } irq_state_t;
endpackage

// File: rtl/dcuart_chan.sv
module dcuart_chan
    import dcuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              hold_rd_i,
    input  logic              hold_wr_i,
    input  logic              cmd_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] hold_o,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              flush_o
);
    chan_state_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.tx_vld = hold_wr_i;
        st_d.flush  = cmd_wr_i && wdata_i[FLUSH_BIT];
        if (hold_wr_i) st_d.tx_byte = wdata_i;
        if (rx_valid_i) begin
            st_d.hold = rx_data_i;
            st_d.full = 1'b1;
            if (st_q.full && !hold_rd_i) st_d.ovr = 1'b1;
        end else if (hold_rd_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o    = '0;
        status_o[0] = st_q.full;
        status_o[2] = 1'b1;
        status_o[4] = st_q.ovr;
    end

    assign hold_o     = st_q.hold;
    assign tx_valid_o = st_q.tx_vld;
    assign tx_data_o  = st_q.tx_byte;
    assign flush_o    = st_q.flush;

    assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> $past(hold_wr_i));
    assert_flush_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> ($past(cmd_wr_i) && $past(wdata_i[FLUSH_BIT])));
    assert_ovr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |=> st_q.ovr);
endmodule

// File: rtl/dcuart_irq.sv
module dcuart_irq
    import dcuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rx_arrive_i,
    input  logic [NUM_CH-1:0] rx_clear_i,
    input  logic [NUM_CH-1:0] tx_clear_i,
    input  logic              tick_i,
    input  logic              mask_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              stat_a_rd_i,
    output logic [BYTE_W-1:0] isr_o,
    output logic              irq_o
);
    irq_state_t st_q, st_d;
    logic       tick_fire;
    logic       set_any;

    always_comb begin
        st_d      = st_q;
        set_any   = 1'b0;
        tick_fire = 1'b0;
        if (tick_i) begin
            st_d.seq  = ~st_q.seq;
            tick_fire = st_q.seq && (st_q.imr[TXR_BIT] || st_q.imr[4 + TXR_BIT]);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (rx_clear_i[c]) st_d.isr[4*c + RXR_BIT] = 1'b0;
            if (tx_clear_i[c]) st_d.isr[4*c + TXR_BIT] = 1'b0;
            if (rx_arrive_i[c] && st_q.imr[4*c + RXR_BIT]) begin
                st_d.isr[4*c + RXR_BIT] = 1'b1;
                set_any = 1'b1;
            end
            if (tick_fire) st_d.isr[4*c + TXR_BIT] = 1'b1;
        end
        if (tick_fire) set_any = 1'b1;
        if (mask_wr_i) st_d.imr = wdata_i;
        if (set_any)          st_d.irq = 1'b1;
        else if (stat_a_rd_i) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isr_o = st_q.isr;
    assign irq_o = st_q.irq;

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_a_rd_i && !set_any) |=> !irq_o);
    assert_rx_set_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_arrive_i[0] && st_q.imr[RXR_BIT]) |=> (isr_o[RXR_BIT] && irq_o));
    assert_rx_set_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_arrive_i[1] && st_q.imr[4 + RXR_BIT]) |=> (isr_o[4 + RXR_BIT] && irq_o));
endmodule

// File: rtl/dcuart_frontend.sv
module dcuart_frontend
    import dcuart_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid_i,
    input  logic                     bus_write_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [BYTE_W-1:0]        bus_wdata_i,
    output logic [BYTE_W-1:0]        bus_rdata_o,
    input  logic [NUM_CH-1:0]        rx_valid_i,
    input  logic [NUM_CH*BYTE_W-1:0] rx_data_i,
    output logic [NUM_CH-1:0]        tx_valid_o,
    output logic [NUM_CH*BYTE_W-1:0] tx_data_o,
    output logic [NUM_CH-1:0]        flush_o,
    input  logic                     tick_i,
    output logic                     irq_o
);
    logic              rd_en, wr_en;
    logic [NUM_CH-1:0] stat_rd, hold_rd, hold_wr, cmd_wr;
    logic              intr_rd, intr_wr;
    logic [BYTE_W-1:0] ch_status [NUM_CH];
    logic [BYTE_W-1:0] ch_hold   [NUM_CH];
    logic [BYTE_W-1:0] isr;
    logic [BYTE_W-1:0] rdata_q, rdata_d;

    assign rd_en   = bus_valid_i && !bus_write_i;
    assign wr_en   = bus_valid_i &&  bus_write_i;
    assign intr_rd = rd_en && (bus_addr_i == ADDR_W'(OFF_INTR));
    assign intr_wr = wr_en && (bus_addr_i == ADDR_W'(OFF_INTR));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(c*CH_STRIDE + OFF_STAT);
        localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(c*CH_STRIDE + OFF_CMD);
        localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(c*CH_STRIDE + OFF_HOLD);

        assign stat_rd[c] = rd_en && (bus_addr_i == A_STAT);
        assign hold_rd[c] = rd_en && (bus_addr_i == A_HOLD);
        assign hold_wr[c] = wr_en && (bus_addr_i == A_HOLD);
        assign cmd_wr[c]  = wr_en && (bus_addr_i == A_CMD);

        dcuart_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .rx_valid_i (rx_valid_i[c]),
            .rx_data_i  (rx_data_i[c*BYTE_W +: BYTE_W]),
            .hold_rd_i  (hold_rd[c]),
            .hold_wr_i  (hold_wr[c]),
            .cmd_wr_i   (cmd_wr[c]),
            .wdata_i    (bus_wdata_i),
            .status_o   (ch_status[c]),
            .hold_o     (ch_hold[c]),
            .tx_valid_o (tx_valid_o[c]),
            .tx_data_o  (tx_data_o[c*BYTE_W +: BYTE_W]),
            .flush_o    (flush_o[c])
        );
    end

    dcuart_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_arrive_i (rx_valid_i),
        .rx_clear_i  (hold_rd),
        .tx_clear_i  (hold_wr),
        .tick_i      (tick_i),
        .mask_wr_i   (intr_wr),
        .wdata_i     (bus_wdata_i),
        .stat_a_rd_i (stat_rd[0]),
        .isr_o       (isr),
        .irq_o       (irq_o)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            rdata_d = '0;
            if (intr_rd) rdata_d = isr;
            for (int c = 0; c < NUM_CH; c++) begin
                if (stat_rd[c]) rdata_d = ch_status[c];
                if (hold_rd[c]) rdata_d = ch_hold[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata_o = rdata_q;

    assert_stat_txrdy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_rd[0] || stat_rd[1]) |-> bus_rdata_o[2]);
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !intr_rd && (stat_rd == '0) && (hold_rd == '0)) |=> (bus_rdata_o == '0));
endmodule

// File: tb/dcuart_frontend_tb_top.sv
module dcuart_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  rx_valid = '0;
    logic [15:0] rx_data = '0;
    logic [1:0]  tx_valid, flush;
    logic [15:0] tx_data;
    logic        tick = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    dcuart_frontend dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid), .bus_write_i(bus_write),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .flush_o(flush),
        .tick_i(tick), .irq_o(irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read data one edge after each read strobe
    always @(posedge clk) begin
        logic issued;
        issued = bus_valid && !bus_write;
        #2;
        if (issued) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty actual=%0h expected=none", bus_rdata);
            end else begin
                chk({8'h0, bus_rdata}, {8'h0, exp_q.pop_front()}, tag_q.pop_front());
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; rx_valid = '0; tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        rx_valid = '0; tick = 1'b0;
        idle();
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        rx_valid = '0; tick = 1'b0;
        idle();
    endtask

    task automatic rx(input int ch, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b0;
        rx_valid = '0; rx_valid[ch] = 1'b1; rx_data[ch*8 +: 8] = d;
        idle();
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        bus_valid = 1'b0; tick = 1'b1;
        idle();
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({15'h0, irq}, 16'h0, "R11 irq after reset");
        chk({12'h0, tx_valid, flush}, 16'h0, "R11 pulses after reset");
        rd(8'h0C, 8'h04, "R11 R1 status A reset");
        rd(8'h4C, 8'h04, "R11 status B reset");
        rd(8'h2C, 8'h00, "R11 isr reset");

        // R4 / R5 channel A receive interrupt
        wr(8'h2C, 8'h22);
        rd(8'h2C, 8'h00, "R4 read returns status not mask");
        rx(0, 8'h5A);
        chk({15'h0, irq}, 16'h1, "R5 irq after A arrival");
        rd(8'h2C, 8'h02, "R4 R5 isr A rx bit");
        rd(8'h0C, 8'h05, "R1 status A byte waiting");
        chk({15'h0, irq}, 16'h0, "R8 A status read drops irq");
        rd(8'h1C, 8'h5A, "R2 hold A data");
        rd(8'h0C, 8'h04, "R2 status A cleared");
        rd(8'h2C, 8'h00, "R2 isr A rx cleared");

        // channel B, R8 and R3
        rx(1, 8'h33);
        chk({15'h0, irq}, 16'h1, "R5 irq after B arrival");
        rd(8'h2C, 8'h20, "R4 isr B rx bit");
        rd(8'h4C, 8'h05, "R1 status B byte waiting");
        chk({15'h0, irq}, 16'h1, "R8 B status read keeps irq");
        rx(1, 8'h44);
        rd(8'h4C, 8'h15, "R3 overrun flag");
        rd(8'h5C, 8'h44, "R3 newer byte kept");
        rd(8'h4C, 8'h14, "R3 overrun sticky");
        rd(8'h0C, 8'h04, "R8 clear via A status");
        chk({15'h0, irq}, 16'h0, "R8 irq low");

        // R5 masked arrival
        wr(8'h2C, 8'h00);
        rx(0, 8'h11);
        chk({15'h0, irq}, 16'h0, "R5 masked arrival no irq");
        rd(8'h2C, 8'h00, "R5 masked arrival no status");
        rd(8'h0C, 8'h05, "R1 masked byte still waits");
        rd(8'h1C, 8'h11, "R2 masked byte data");

        // R6 tick divider, R7 transmit
        wr(8'h2C, 8'h01);
        pulse_tick();
        chk({15'h0, irq}, 16'h0, "R6 first tick silent");
        rd(8'h2C, 8'h00, "R6 first tick no status");
        pulse_tick();
        chk({15'h0, irq}, 16'h1, "R6 second tick irq");
        rd(8'h2C, 8'h11, "R6 both tx bits");
        rd(8'h0C, 8'h04, "R8 clear after tick");
        wr(8'h1C, 8'h41);
        chk({14'h0, tx_valid}, 16'h1, "R7 tx pulse A");
        chk({8'h0, tx_data[7:0]}, 16'h41, "R7 tx byte A");
        @(negedge clk);
        chk({14'h0, tx_valid}, 16'h0, "R7 tx pulse one cycle");
        rd(8'h2C, 8'h10, "R7 A tx bit cleared");
        wr(8'h5C, 8'h42);
        chk({14'h0, tx_valid}, 16'h2, "R7 tx pulse B");
        chk({8'h0, tx_data[15:8]}, 16'h42, "R7 tx byte B");
        rd(8'h2C, 8'h00, "R7 B tx bit cleared");
        wr(8'h2C, 8'h00);
        pulse_tick();
        pulse_tick();
        rd(8'h2C, 8'h00, "R6 masked ticks no status");
        chk({15'h0, irq}, 16'h0, "R6 masked ticks no irq");

        // R9 flush
        wr(8'h14, 8'h08);
        chk({14'h0, flush}, 16'h1, "R9 flush A");
        @(negedge clk);
        chk({14'h0, flush}, 16'h0, "R9 flush one cycle");
        wr(8'h54, 8'h04);
        chk({14'h0, flush}, 16'h0, "R9 no flush without bit3");
        wr(8'h54, 8'h0F);
        chk({14'h0, flush}, 16'h2, "R9 flush B");

        // R10 ignored and unmapped offsets
        wr(8'h04, 8'hFF);
        wr(8'h24, 8'hFF);
        wr(8'h34, 8'hFF);
        wr(8'h7C, 8'hFF);
        chk({12'h0, tx_valid, flush}, 16'h0, "R10 writes no pulses");
        rd(8'h04, 8'h00, "R10 mode reads zero");
        rd(8'h34, 8'h00, "R10 counter reads zero");
        rd(8'h7C, 8'h00, "R10 unmapped reads zero");
        rd(8'h2C, 8'h00, "R10 isr untouched");
        rd(8'h0C, 8'h04, "R10 status A untouched");
        chk({15'h0, irq}, 16'h0, "R10 irq untouched");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule